// File: doc/BRIEF.md
# Demand Read Error Handler with Single Retry

This block sits on the read-return path of a memory controller. It takes one request at a time from a requester and forwards reads to memory. It then looks at the ECC status returned with each cache line. A line with a correctable error goes back to the requester with the corrected data, and the block also schedules a scrub write of that data to the same line. A line with an uncorrectable error on a demand read is not returned. Instead the whole cache line is requested from memory a second time. Only a second uncorrectable result is reported as a hard error, and that response carries a poison flag. If the second read comes back clean or correctable, the error is logged as transient.

Reads raised by the scrub engine use the same path but are never retried and never produce a scrub write. Requester writes pass through the block to the memory write port. A requester write to the line of a pending scrub write cancels that scrub write. Three saturating counters record correctable, transient and hard events, and each event also has a one-cycle pulse output.

Top module: `dmd_rd_guard`

## Requirements
- R1: After reset, no valid output is asserted, all three counters read zero and `rq_ready_o` is high for an idle read request.
- R2: A read sends one memory request to the requested line address. One cycle after `mp_valid_i`, `rs_valid_o` pulses for one cycle with the request's tag and the returned data. The status code `mp_ecc_i` is 00 for clean, 01 for correctable, and 10 or 11 for uncorrectable. Poison is low for clean and correctable returns.
- R3: When a demand read (`rq_scrub_i`=0) first returns uncorrectable, the same line address is requested exactly once more. No response is given before the second return.
- R4: If the retry returns clean or correctable, the retry's data is returned without poison and `ev_transient_o` pulses. If the retry returns uncorrectable, the response is poisoned and `ev_hard_o` pulses.
- R5: A read with `rq_scrub_i`=1 is never retried. An uncorrectable return on such a read gives a poisoned response with no hard or transient event.
- R6: When a demand read's final return is correctable, exactly one write goes out on the memory write port. It carries the returned data, the same line address and `mw_scrub_o`=1. A scrub-source read produces no write.
- R7: A requester write to the same line address, accepted before the pending scrub write is issued, cancels that scrub write. Only the requester's write reaches the write port.
- R8: A requester write to a different line is forwarded first. The pending scrub write still follows it.
- R9: `ev_ce_o` pulses with every response whose final return is correctable. The correctable, transient and hard counters each increase by one per matching event and stop at their all-ones value.
- R10: `mr_valid_o` and `mr_addr_o` stay unchanged while `mr_ready_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rq_valid_i | input | 1 | Requester request valid |
| rq_ready_o | output | 1 | Request accepted this cycle |
| rq_write_i | input | 1 | 1 = write, 0 = read |
| rq_scrub_i | input | 1 | Read raised by the scrub engine |
| rq_addr_i | input | AW | Line address |
| rq_tag_i | input | TW | Request tag |
| rq_wdata_i | input | DW | Write data |
| rs_valid_o | output | 1 | Read response pulse |
| rs_tag_o | output | TW | Response tag |
| rs_data_o | output | DW | Response data |
| rs_poison_o | output | 1 | Data is uncorrectable |
| mr_valid_o | output | 1 | Memory read request valid |
| mr_ready_i | input | 1 | Memory accepts read request |
| mr_addr_o | output | AW | Memory read line address |
| mp_valid_i | input | 1 | Memory read return valid |
| mp_data_i | input | DW | Returned (corrected) line data |
| mp_ecc_i | input | 2 | ECC status of the return |
| mw_valid_o | output | 1 | Memory write valid |
| mw_ready_i | input | 1 | Memory accepts write |
| mw_addr_o | output | AW | Memory write line address |
| mw_data_o | output | DW | Memory write data |
| mw_scrub_o | output | 1 | Write is a demand scrub write-back |
| ev_ce_o | output | 1 | Correctable event pulse |
| ev_transient_o | output | 1 | Retry-cleared error pulse |
| ev_hard_o | output | 1 | Hard uncorrectable error pulse |
| cnt_ce_o | output | CW | Correctable counter |
| cnt_transient_o | output | CW | Transient counter |
| cnt_hard_o | output | CW | Hard error counter |

## Verification
The hardest case to reach is the race between a pending scrub write-back and a requester write. The write has to be accepted on the very cycle the scrub entry would otherwise move to the write port. The bench therefore drives the requester write on the same falling edge on which the correctable response appears, while the write port is still empty. It runs this for a matching line address, which must cancel the scrub write, and for a different address, which must leave the scrub write queued behind the requester write. The main sweep covers every pair of first and second return status, for both demand and scrub-source reads. It also holds the memory request stalled on each attempt.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} dmd_st_e;

  localparam int unsigned N_EVT = 3;
  localparam int unsigned EV_CE = 0;
  localparam int unsigned EV_TR = 1;
  localparam int unsigned EV_HD = 2;

  function automatic logic ecc_ue(input logic [1:0] c);
    return c[1];
  endfunction

  function automatic logic ecc_ce(input logic [1:0] c);
    return !c[1] && c[0];
  endfunction
endpackage

// File: rtl/dmd_sat_cnt.sv
module dmd_sat_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] MAX = {CW{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAX) |=> (cnt_o == MAX)); // R9
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i) |=> $stable(cnt_o)); // R9
endmodule

// File: rtl/dmd_wr_port.sv
module dmd_wr_port #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sb_load_i,
  input  logic [AW-1:0] sb_addr_i,
  input  logic [DW-1:0] sb_data_i,
  input  logic          wr_acc_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          sb_busy_o,
  output logic          wo_busy_o,
  output logic          mw_valid_o,
  input  logic          mw_ready_i,
  output logic [AW-1:0] mw_addr_o,
  output logic [DW-1:0] mw_data_o,
  output logic          mw_scrub_o
);
  logic          sb_v_q;
  logic [AW-1:0] sb_addr_q;
  logic [DW-1:0] sb_data_q;
  logic          sb_hit;
  logic          sb_move;

  assign sb_hit  = wr_acc_i && sb_v_q && (wr_addr_i == sb_addr_q);
  assign sb_move = sb_v_q && !mw_valid_o && !wr_acc_i;

  // scrub write-back buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sb_v_q    <= 1'b0;
      sb_addr_q <= '0;
      sb_data_q <= '0;
    end else if (sb_load_i) begin
      sb_v_q    <= 1'b1;
      sb_addr_q <= sb_addr_i;
      sb_data_q <= sb_data_i;
    end else if (sb_hit || sb_move) begin
      sb_v_q <= 1'b0;
    end
  end

  // write output stage; requester writes win over the scrub entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mw_valid_o <= 1'b0;
      mw_addr_o  <= '0;
      mw_data_o  <= '0;
      mw_scrub_o <= 1'b0;
    end else if (mw_valid_o) begin
      if (mw_ready_i) mw_valid_o <= 1'b0;
    end else if (wr_acc_i) begin
      mw_valid_o <= 1'b1;
      mw_addr_o  <= wr_addr_i;
      mw_data_o  <= wr_data_i;
      mw_scrub_o <= 1'b0;
    end else if (sb_v_q) begin
      mw_valid_o <= 1'b1;
      mw_addr_o  <= sb_addr_q;
      mw_data_o  <= sb_data_q;
      mw_scrub_o <= 1'b1;
    end
  end

  assign sb_busy_o = sb_v_q;
  assign wo_busy_o = mw_valid_o;

  AST_SB_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_load_i |-> !sb_v_q); // R6
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mw_valid_o && !mw_ready_i) |=> (mw_valid_o && $stable(mw_addr_o) && $stable(mw_data_o))); // R8
  AST_WR_NO_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc_i |-> !mw_valid_o); // R7
endmodule

// File: rtl/dmd_rd_guard.sv
module dmd_rd_guard
  import dmd_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 64,
  parameter int unsigned TW = 4,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rq_valid_i,
  output logic          rq_ready_o,
  input  logic          rq_write_i,
  input  logic          rq_scrub_i,
  input  logic [AW-1:0] rq_addr_i,
  input  logic [TW-1:0] rq_tag_i,
  input  logic [DW-1:0] rq_wdata_i,
  output logic          rs_valid_o,
  output logic [TW-1:0] rs_tag_o,
  output logic [DW-1:0] rs_data_o,
  output logic          rs_poison_o,
  output logic          mr_valid_o,
  input  logic          mr_ready_i,
  output logic [AW-1:0] mr_addr_o,
  input  logic          mp_valid_i,
  input  logic [DW-1:0] mp_data_i,
  input  logic [1:0]    mp_ecc_i,
  output logic          mw_valid_o,
  input  logic          mw_ready_i,
  output logic [AW-1:0] mw_addr_o,
  output logic [DW-1:0] mw_data_o,
  output logic          mw_scrub_o,
  output logic          ev_ce_o,
  output logic          ev_transient_o,
  output logic          ev_hard_o,
  output logic [CW-1:0] cnt_ce_o,
  output logic [CW-1:0] cnt_transient_o,
  output logic [CW-1:0] cnt_hard_o
);
  dmd_st_e       st_q;
  logic [AW-1:0] addr_q;
  logic [TW-1:0] tag_q;
  logic          src_scrub_q;
  logic          retry_q;

  logic          sb_busy, wo_busy;
  logic          rd_acc, wr_acc, mp_take, ue, ce, do_retry, finish;
  logic [N_EVT-1:0]         inc;
  logic [N_EVT-1:0]         ev_q;
  logic [N_EVT-1:0][CW-1:0] cnt;

  assign rq_ready_o = (st_q == ST_IDLE) && (rq_write_i ? !wo_busy : !sb_busy);
  assign rd_acc     = rq_valid_i && rq_ready_o && !rq_write_i;
  assign wr_acc     = rq_valid_i && rq_ready_o && rq_write_i;

  assign mp_take  = (st_q == ST_WAIT) && mp_valid_i;
  assign ue       = ecc_ue(mp_ecc_i);
  assign ce       = ecc_ce(mp_ecc_i);
  assign do_retry = mp_take && ue && !retry_q && !src_scrub_q;
  assign finish   = mp_take && !do_retry;

  assign inc[EV_CE] = finish && ce;
  assign inc[EV_TR] = finish && retry_q && !ue;
  assign inc[EV_HD] = finish && retry_q && ue;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      addr_q      <= '0;
      tag_q       <= '0;
      src_scrub_q <= 1'b0;
      retry_q     <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (rd_acc) begin
          st_q        <= ST_ISSUE;
          addr_q      <= rq_addr_i;
          tag_q       <= rq_tag_i;
          src_scrub_q <= rq_scrub_i;
          retry_q     <= 1'b0;
        end
        ST_ISSUE: if (mr_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (do_retry) begin
          st_q    <= ST_ISSUE;
          retry_q <= 1'b1;
        end else if (finish) begin
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mr_valid_o = (st_q == ST_ISSUE);
  assign mr_addr_o  = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_valid_o  <= 1'b0;
      rs_tag_o    <= '0;
      rs_data_o   <= '0;
      rs_poison_o <= 1'b0;
      ev_q        <= '0;
    end else begin
      rs_valid_o <= finish;
      ev_q       <= inc;
      if (finish) begin
        rs_tag_o    <= tag_q;
        rs_data_o   <= mp_data_i;
        rs_poison_o <= ue;
      end
    end
  end

  assign ev_ce_o        = ev_q[EV_CE];
  assign ev_transient_o = ev_q[EV_TR];
  assign ev_hard_o      = ev_q[EV_HD];

  dmd_wr_port #(.AW(AW), .DW(DW)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sb_load_i  (finish && ce && !src_scrub_q),
    .sb_addr_i  (addr_q),
    .sb_data_i  (mp_data_i),
    .wr_acc_i   (wr_acc),
    .wr_addr_i  (rq_addr_i),
    .wr_data_i  (rq_wdata_i),
    .sb_busy_o  (sb_busy),
    .wo_busy_o  (wo_busy),
    .mw_valid_o (mw_valid_o),
    .mw_ready_i (mw_ready_i),
    .mw_addr_o  (mw_addr_o),
    .mw_data_o  (mw_data_o),
    .mw_scrub_o (mw_scrub_o)
  );

  for (genvar g = 0; g < N_EVT; g++) begin : g_cnt
    dmd_sat_cnt #(.CW(CW)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[g]),
      .cnt_o  (cnt[g])
    );
  end

  assign cnt_ce_o        = cnt[EV_CE];
  assign cnt_transient_o = cnt[EV_TR];
  assign cnt_hard_o      = cnt[EV_HD];

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_o |=> !rs_valid_o); // R2
  AST_ONE_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mp_take && retry_q) |=> !mr_valid_o); // R3
  AST_SCRUB_SRC_NO_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mr_valid_o && src_scrub_q) |-> !retry_q); // R5
  AST_HARD_POISON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_hard_o |-> (rs_valid_o && rs_poison_o)); // R4
  AST_TRANSIENT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_transient_o |-> (rs_valid_o && !rs_poison_o)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mr_valid_o && !mr_ready_i) |=> (mr_valid_o && $stable(mr_addr_o))); // R10
  AST_EV_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_transient_o, ev_hard_o})); // R4
endmodule

// File: tb/sim_dmd_rd_guard.sv
module sim_dmd_rd_guard;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int TW = 3;
  localparam int CW = 2;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rq_valid = 0, rq_write = 0, rq_scrub = 0;
  logic [AW-1:0] rq_addr = '0;
  logic [TW-1:0] rq_tag = '0;
  logic [DW-1:0] rq_wdata = '0;
  logic          rq_ready;
  logic          rs_valid, rs_poison;
  logic [TW-1:0] rs_tag;
  logic [DW-1:0] rs_data;
  logic          mr_valid;
  logic          mr_ready = 0;
  logic [AW-1:0] mr_addr;
  logic          mp_valid = 0;
  logic [DW-1:0] mp_data = '0;
  logic [1:0]    mp_ecc = '0;
  logic          mw_valid, mw_scrub;
  logic          mw_ready = 0;
  logic [AW-1:0] mw_addr;
  logic [DW-1:0] mw_data;
  logic          ev_ce, ev_tr, ev_hd;
  logic [CW-1:0] c_ce, c_tr, c_hd;

  int n_chk = 0, n_err = 0;
  int m_ce = 0, m_tr = 0, m_hd = 0;

  always #4 clk = ~clk;

  dmd_rd_guard #(.AW(AW), .DW(DW), .TW(TW), .CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rq_valid_i(rq_valid), .rq_ready_o(rq_ready), .rq_write_i(rq_write),
    .rq_scrub_i(rq_scrub), .rq_addr_i(rq_addr), .rq_tag_i(rq_tag), .rq_wdata_i(rq_wdata),
    .rs_valid_o(rs_valid), .rs_tag_o(rs_tag), .rs_data_o(rs_data), .rs_poison_o(rs_poison),
    .mr_valid_o(mr_valid), .mr_ready_i(mr_ready), .mr_addr_o(mr_addr),
    .mp_valid_i(mp_valid), .mp_data_i(mp_data), .mp_ecc_i(mp_ecc),
    .mw_valid_o(mw_valid), .mw_ready_i(mw_ready), .mw_addr_o(mw_addr),
    .mw_data_o(mw_data), .mw_scrub_o(mw_scrub),
    .ev_ce_o(ev_ce), .ev_transient_o(ev_tr), .ev_hard_o(ev_hd),
    .cnt_ce_o(c_ce), .cnt_transient_o(c_tr), .cnt_hard_o(c_hd)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] gen(input logic [AW-1:0] a, input int att);
    return {a, ~a} ^ (att != 0 ? 16'h5a5a : 16'h0000);
  endfunction

  task automatic expect_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit s, input string req);
    int n = 0;
    while (!mw_valid && n < 6) begin @(negedge clk); n++; end
    chk(mw_valid == 1'b1, req, "write valid", mw_valid, 1);
    chk(mw_addr == a, req, "write addr", mw_addr, a);
    chk(mw_data == d, req, "write data", mw_data, d);
    chk(mw_scrub == s, req, "write scrub flag", mw_scrub, s);
    mw_ready = 1'b1;
    @(negedge clk);
    mw_ready = 1'b0;
  endtask

  task automatic expect_no_wr(input string req);
    bit seen = 0;
    for (int k = 0; k < 4; k++) begin
      if (mw_valid) seen = 1;
      @(negedge clk);
    end
    chk(!seen, req, "no write", seen, 0);
  endtask

  // post: 0 plain, 1 same-line requester write, 2 other-line requester write
  task automatic do_read(input logic [AW-1:0] a, input logic [TW-1:0] t, input bit s,
                         input logic [1:0] e0, input logic [1:0] e1, input int post);
    int att = 0;
    bit retry_x = e0[1] && !s;
    logic [1:0] fin = retry_x ? e1 : e0;
    bit fue = fin[1];
    bit fce = !fin[1] && fin[0];
    bit done = 0;
    rq_valid = 1; rq_write = 0; rq_addr = a; rq_tag = t; rq_scrub = s;
    #1;
    while (!rq_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rq_valid = 0;
    for (int k = 0; k < 3 && !done; k++) begin
      int n = 0;
      while (!mr_valid && n < 10) begin @(negedge clk); n++; end
      chk(mr_valid == 1'b1, "R2", "mem request", mr_valid, 1);
      chk(mr_addr == a, "R3", "mem request addr", mr_addr, a);
      @(negedge clk);
      chk(mr_valid == 1'b1 && mr_addr == a, "R10", "request held", mr_valid, 1);
      mr_ready = 1;
      @(negedge clk);
      mr_ready = 0;
      chk(!rs_valid && !mr_valid, "R3", "quiet while waiting", rs_valid, 0);
      @(negedge clk);
      mp_valid = 1; mp_ecc = (att == 0) ? e0 : e1; mp_data = gen(a, att);
      @(negedge clk);
      mp_valid = 0;
      att++;
      if (rs_valid) done = 1;
    end
    if (fce) m_ce = (m_ce < CMAX) ? m_ce + 1 : CMAX;
    if (retry_x && !fue) m_tr = (m_tr < CMAX) ? m_tr + 1 : CMAX;
    if (retry_x && fue) m_hd = (m_hd < CMAX) ? m_hd + 1 : CMAX;
    chk(att == (retry_x ? 2 : 1), s ? "R5" : "R3", "read attempts", att, retry_x ? 2 : 1);
    chk(rs_valid == 1'b1, "R2", "response valid", rs_valid, 1);
    chk(rs_tag == t, "R2", "response tag", rs_tag, t);
    chk(rs_data == gen(a, att - 1), "R2", "response data", rs_data, gen(a, att - 1));
    chk(rs_poison == fue, retry_x ? "R4" : (s ? "R5" : "R2"), "poison", rs_poison, fue);
    chk(ev_tr == (retry_x && !fue), "R4", "transient event", ev_tr, retry_x && !fue);
    chk(ev_hd == (retry_x && fue), s ? "R5" : "R4", "hard event", ev_hd, retry_x && fue);
    chk(ev_ce == fce, "R9", "ce event", ev_ce, fce);
    chk(c_ce == m_ce, "R9", "ce counter", c_ce, m_ce);
    chk(c_tr == m_tr, "R9", "transient counter", c_tr, m_tr);
    chk(c_hd == m_hd, "R9", "hard counter", c_hd, m_hd);
    if (post == 1) begin
      rq_valid = 1; rq_write = 1; rq_addr = a; rq_wdata = 16'hbeef;
      #1;
      chk(rq_ready == 1'b1, "R7", "write accepted", rq_ready, 1);
      @(negedge clk);
      rq_valid = 0; rq_write = 0;
      expect_wr(a, 16'hbeef, 1'b0, "R7");
      expect_no_wr("R7");
    end else if (post == 2) begin
      rq_valid = 1; rq_write = 1; rq_addr = a ^ 8'h80; rq_wdata = 16'hcafe;
      #1;
      chk(rq_ready == 1'b1, "R8", "write accepted", rq_ready, 1);
      @(negedge clk);
      rq_valid = 0; rq_write = 0;
      expect_wr(a ^ 8'h80, 16'hcafe, 1'b0, "R8");
      expect_wr(a, gen(a, att - 1), 1'b1, "R8");
      expect_no_wr("R8");
    end else if (fce && !s) begin
      expect_wr(a, gen(a, att - 1), 1'b1, "R6");
      expect_no_wr("R6");
    end else begin
      expect_no_wr(s ? "R6" : "R2");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(!rs_valid && !mr_valid && !mw_valid, "R1", "valids idle", {rs_valid, mr_valid, mw_valid}, 0);
    chk(!ev_ce && !ev_tr && !ev_hd, "R1", "events idle", {ev_ce, ev_tr, ev_hd}, 0);
    chk(c_ce == 0 && c_tr == 0 && c_hd == 0, "R1", "counters zero", {c_ce, c_tr, c_hd}, 0);
    chk(rq_ready == 1'b1, "R1", "ready idle", rq_ready, 1);
    @(negedge clk);
    for (int s = 0; s < 2; s++)
      for (int e0 = 0; e0 < 3; e0++)
        for (int e1 = 0; e1 < 3; e1++)
          do_read(8'(8'h10 + s * 16 + e0 * 3 + e1), 3'(e0 * 3 + e1 + s),
                  s[0], (e0 == 2 && e1 == 1) ? 2'b11 : 2'(e0), 2'(e1), 0);
    do_read(8'h41, 3'd5, 1'b0, 2'b01, 2'b00, 1);
    do_read(8'h42, 3'd6, 1'b0, 2'b10, 2'b01, 1);
    do_read(8'h43, 3'd7, 1'b0, 2'b01, 2'b00, 2);
    do_read(8'h44, 3'd1, 1'b0, 2'b11, 2'b11, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule